// File: doc/BRIEF.md
# SPI Target with Single-Word Transmit Holding Register

This block is the serial side of a peripheral that answers an external SPI controller. Software places one word into a transmit holding register. The block moves that word into a shift register and sends it most significant bit first on SDO while it samples SDI. When a whole word has arrived, the received bits go to a receive buffer and the block raises a flag. An interrupt flag follows one system clock later.

The word length is 8 or 16 bits. Clock polarity and clock phase can be set in any of the four combinations. The serial inputs come in through two-flop synchronisers, and the block finds SCK edges by oversampling with the system clock. The main design choice is a slave-select enable input. When it is off, the SS input is ignored and the holding register empties as soon as its word enters the shift register. When it is on, the holding register keeps its word until the last bit has gone out. If SS rises in the middle of a word, the transfer is abandoned and the same word is sent again from its first bit at the next selection.

Top module: `spi_tgt_xbuf`

## Requirements
- R1: After reset, tx_full, rx_full, rx_ovf and irq are 0, rx_rdata is 0 and sdo is low.
- R2: A tx_wr pulse while tx_full is 0 stores tx_wdata and sets tx_full in the next cycle. A tx_wr pulse while tx_full is 1 is ignored, and the stored word is not changed.
- R3: With cfg_sel_en = 0, the held word is copied into the shift register one cycle after it is written, as soon as the shift register is free. tx_full clears in that same cycle. The ss_n input has no effect in this mode.
- R4: With cfg_sel_en = 1, tx_full stays at 1 for the whole transfer. It clears in the cycle the final bit of the word is sampled.
- R5: With cfg_sel_en = 1, ss_n going high before the final bit abandons the word. The partial receive data is discarded, no flag changes, and the held word is sent again in full when ss_n goes low again. sdo is driven low while ss_n is high.
- R6: Data moves most significant bit first. With cfg_wide = 1 a word is bits [15:0]. With cfg_wide = 0 a word is bits [7:0], and the received value is zero-extended to 16 bits.
- R7: cfg_pol is the SCK idle level. With cfg_pha = 0, SDI is sampled on the edge leaving idle and SDO changes on the edge returning to idle. With cfg_pha = 1 these two roles swap. All four combinations work.
- R8: When a word completes and rx_full is 0, the word appears on rx_rdata and rx_full sets. irq rises exactly one cycle after rx_full rises.
- R9: When a word completes while rx_full is 1, rx_ovf sets and stays set, and rx_rdata keeps the older word. An ovf_clr pulse clears rx_ovf.
- R10: An rx_rd pulse clears rx_full. An irq_clr pulse clears irq.
- R11: A transfer that runs while no word is loaded sends all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pol | input | 1 | SCK idle level |
| cfg_pha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| cfg_wide | input | 1 | 1: 16-bit words; 0: 8-bit words |
| cfg_sel_en | input | 1 | 1: ss_n frames transfers and the word is kept until fully sent |
| tx_wr | input | 1 | One-cycle write strobe for the transmit holding register |
| tx_wdata | input | 16 | Transmit word |
| rx_rd | input | 1 | One-cycle read strobe; clears rx_full |
| rx_rdata | output | 16 | Receive buffer contents |
| irq_clr | input | 1 | One-cycle pulse that clears irq |
| ovf_clr | input | 1 | One-cycle pulse that clears rx_ovf |
| tx_full | output | 1 | Holding register occupied |
| rx_full | output | 1 | Receive buffer holds an unread word |
| rx_ovf | output | 1 | Sticky flag: a received word was dropped |
| irq | output | 1 | Word-received interrupt flag |
| sck | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data into the block |
| ss_n | input | 1 | Active-low select, used only when cfg_sel_en is 1 |
| sdo | output | 1 | Serial data out of the block |

## Verification
The bench steps through all sixteen combinations of polarity, phase, word length and select enable. In each one it runs the same sequence and checks every step against values it computes itself:
- A first loaded word, preceded by an abandoned partial transfer when select is enabled. This separates the retry path from a fresh load.
- A transfer with nothing loaded. This shows that zeros are sent and that a second word arriving before the first is read causes an overflow.
- Two back-to-back writes, with a third write while the register is full. In select-disabled mode the early hand-off lets the second write be accepted. In select-enabled mode the word is kept until sent, so the second write is refused.

Comparing the received serial words against the values written shows whether the edge roles are correct. It also shows whether bits are sent MSB first and whether the word length is honoured.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
    // Classification of an SCK transition seen in the system clock domain
    typedef enum logic [1:0] {
        EK_NONE = 2'd0,
        EK_SMP  = 2'd1,   // capture SDI
        EK_DRV  = 2'd2    // advance SDO
    } edge_kind_e;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge
    import spi_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_s,
    input  logic       cfg_pol,
    input  logic       cfg_pha,
    output edge_kind_e kind
);
    localparam int WARM_MAX = STAGES + 1;
    localparam int WW       = $clog2(WARM_MAX + 1);

    typedef struct packed {
        logic          prev;
        logic [WW-1:0] warm;
    } st_t;

    st_t st_d, st_q;
    logic leading;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sck_s;
        if (st_q.warm != WW'(WARM_MAX)) st_d.warm = st_q.warm + 1'b1;
        leading = (st_q.prev == cfg_pol);
        kind    = EK_NONE;
        // ignore transitions until the synchroniser chain holds real pin values
        if (st_q.warm == WW'(WARM_MAX) && sck_s != st_q.prev)
            kind = (leading ^ cfg_pha) ? EK_SMP : EK_DRV;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
    import spi_tgt_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_sel_en,
    input  edge_kind_e        kind,
    input  logic              sdi_s,
    input  logic              ss_s,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    output logic              tx_full,
    output logic              sdo,
    output logic              done,
    output logic [WORD_W-1:0] done_word
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_W = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] LAST_N = CNT_W'(NARROW_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic              full;
        logic              pend;   // shift register owns a word (select disabled)
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic [WORD_W-1:0] word;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0]  last;
    logic [WORD_W-1:0] rx_next;
    logic              deselected;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        last       = cfg_wide ? LAST_W : LAST_N;
        rx_next    = {st_q.rx[WORD_W-2:0], sdi_s};
        deselected = cfg_sel_en && ss_s;

        if (deselected) begin
            // abandon any partial word; the held word stays for a retry
            st_d.cnt = '0;
            st_d.rx  = '0;
        end else begin
            if (kind == EK_DRV && st_q.cnt != '0)
                st_d.tx = st_q.tx << 1;
            if (kind == EK_SMP) begin
                st_d.rx = rx_next;
                if (st_q.cnt == last) begin
                    st_d.done = 1'b1;
                    st_d.word = cfg_wide ? rx_next
                                         : {{(WORD_W-NARROW_W){1'b0}}, rx_next[NARROW_W-1:0]};
                    st_d.cnt  = '0;
                    st_d.tx   = '0;
                    if (cfg_sel_en) st_d.full = 1'b0;
                    else            st_d.pend = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end

        // hand the held word to the shift register between words
        if (st_d.full && st_d.cnt == '0) begin
            if (cfg_sel_en) begin
                st_d.tx = st_q.hold;
            end else if (!st_d.pend) begin
                st_d.tx   = st_q.hold;
                st_d.pend = 1'b1;
                st_d.full = 1'b0;
            end
        end

        if (tx_wr && !st_q.full) begin
            st_d.hold = tx_wdata;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_full   = st_q.full;
    assign done      = st_q.done;
    assign done_word = st_q.word;
    assign sdo       = (cfg_sel_en && ss_s) ? 1'b0
                     : (cfg_wide ? st_q.tx[WORD_W-1] : st_q.tx[NARROW_W-1]);

    // R2
    full_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.full) |-> $past(tx_wr));

    // R4
    held_until_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel_en && $fell(st_q.full)) |-> st_q.done);

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= (cfg_wide ? LAST_W : LAST_N));
endmodule

// File: rtl/spi_tgt_rxbuf.sv
module spi_tgt_rxbuf #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [WORD_W-1:0] done_word,
    input  logic              rx_rd,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic [WORD_W-1:0] rx_rdata,
    output logic              rx_full,
    output logic              rx_ovf,
    output logic              irq
);
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              full;
        logic              ovf;
        logic              irq;
        logic              irq_pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.irq_pend = 1'b0;
        if (ovf_clr) st_d.ovf = 1'b0;
        if (rx_rd)   st_d.full = 1'b0;
        if (done) begin
            if (st_q.full && !rx_rd) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.data     = done_word;
                st_d.full     = 1'b1;
                st_d.irq_pend = 1'b1;
            end
        end
        if (st_q.irq_pend) st_d.irq = 1'b1;
        else if (irq_clr)  st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_rdata = st_q.data;
    assign rx_full  = st_q.full;
    assign rx_ovf   = st_q.ovf;
    assign irq      = st_q.irq;

    // R8
    irq_follows_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.full) |=> st_q.irq);

    // R9
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.full && !rx_rd) |=> (st_q.ovf && $stable(st_q.data)));
endmodule

// File: rtl/spi_tgt_xbuf.sv
module spi_tgt_xbuf
    import spi_tgt_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int NARROW_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pol,
    input  logic              cfg_pha,
    input  logic              cfg_wide,
    input  logic              cfg_sel_en,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_rdata,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    output logic              tx_full,
    output logic              rx_full,
    output logic              rx_ovf,
    output logic              irq,
    input  logic              sck,
    input  logic              sdi,
    input  logic              ss_n,
    output logic              sdo
);
    localparam int          N_PINS   = 3;
    localparam logic [2:0]  SYNC_RST = 3'b100;   // {ss_n, sdi, sck}

    logic [N_PINS-1:0] pin_raw, pin_s;
    edge_kind_e        kind;
    logic              done;
    logic [WORD_W-1:0] done_word;

    assign pin_raw = {ss_n, sdi, sck};

    for (genvar g = 0; g < N_PINS; g++) begin : g_sync
        spi_tgt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_raw[g]),
            .dout (pin_s[g])
        );
    end

    spi_tgt_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_s  (pin_s[0]),
        .cfg_pol(cfg_pol),
        .cfg_pha(cfg_pha),
        .kind   (kind)
    );

    spi_tgt_shift #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wide  (cfg_wide),
        .cfg_sel_en(cfg_sel_en),
        .kind      (kind),
        .sdi_s     (pin_s[1]),
        .ss_s      (pin_s[2]),
        .tx_wr     (tx_wr),
        .tx_wdata  (tx_wdata),
        .tx_full   (tx_full),
        .sdo       (sdo),
        .done      (done),
        .done_word (done_word)
    );

    spi_tgt_rxbuf #(.WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .done_word(done_word),
        .rx_rd    (rx_rd),
        .irq_clr  (irq_clr),
        .ovf_clr  (ovf_clr),
        .rx_rdata (rx_rdata),
        .rx_full  (rx_full),
        .rx_ovf   (rx_ovf),
        .irq      (irq)
    );
endmodule

// File: tb/spi_tgt_xbuf_test.sv
module spi_tgt_xbuf_test;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic rst_n, cfg_pol, cfg_pha, cfg_wide, cfg_sel_en;
    logic tx_wr, rx_rd, irq_clr, ovf_clr;
    logic [15:0] tx_wdata, rx_rdata;
    logic tx_full, rx_full, rx_ovf, irq;
    logic sck, sdi, ss_n, sdo;

    spi_tgt_xbuf uut (
        .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .cfg_pha(cfg_pha),
        .cfg_wide(cfg_wide), .cfg_sel_en(cfg_sel_en), .tx_wr(tx_wr),
        .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .irq_clr(irq_clr), .ovf_clr(ovf_clr), .tx_full(tx_full),
        .rx_full(rx_full), .rx_ovf(rx_ovf), .irq(irq), .sck(sck),
        .sdi(sdi), .ss_n(ss_n), .sdo(sdo)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int rxf_at, irq_at;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int c, input int k);
        return 16'((c * 16'h1357 + k * 16'h2A5B) ^ 16'hA5C3);
    endfunction

    task automatic apply_reset();
        rst_n = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; irq_clr = 1'b0; ovf_clr = 1'b0;
        tx_wdata = '0; sck = cfg_pol; sdi = 1'b0; ss_n = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        tx_wdata = d; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic poll(input int n);
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            if (rx_full && rxf_at < 0) rxf_at = t;
            if (irq && irq_at < 0) irq_at = t;
        end
    endtask

    // Controller side: sends mo, returns what came back on sdo
    task automatic xfer(input logic [15:0] mo, input int nb, output logic [15:0] mi);
        int len;
        len = cfg_wide ? 16 : 8;
        mi = '0; rxf_at = -1; irq_at = -1;
        if (cfg_sel_en) ss_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int j = 0; j < nb; j++) begin
            int b;
            b = len - 1 - j;
            if (!cfg_pha) begin
                sdi = mo[b];
                repeat (HALF) @(negedge clk);
                mi[b] = sdo;
                sck = ~cfg_pol;
                if (j == len - 1) poll(HALF + 6);
                else repeat (HALF) @(negedge clk);
                sck = cfg_pol;
            end else begin
                sck = ~cfg_pol;
                sdi = mo[b];
                repeat (HALF) @(negedge clk);
                mi[b] = sdo;
                sck = cfg_pol;
                if (j == len - 1) poll(HALF + 6);
                else repeat (HALF) @(negedge clk);
            end
        end
        repeat (HALF) @(negedge clk);
        ss_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] mi, mask, a, b, c, d;
        int len;
        cfg_pol = 0; cfg_pha = 0; cfg_wide = 0; cfg_sel_en = 0;
        for (int combo = 0; combo < 16; combo++) begin
            cfg_pol    = combo[0];
            cfg_pha    = combo[1];
            cfg_wide   = combo[2];
            cfg_sel_en = combo[3];
            len  = cfg_wide ? 16 : 8;
            mask = cfg_wide ? 16'hFFFF : 16'h00FF;
            apply_reset();
            // R1 reset state
            chk("R1 tx_full", {15'd0, tx_full}, 16'd0);
            chk("R1 flags", {12'd0, rx_full, rx_ovf, irq, sdo}, 16'd0);
            chk("R1 rx_rdata", rx_rdata, 16'd0);

            a = pat(combo, 0) & mask;
            b = pat(combo, 1) & mask;
            c = pat(combo, 2) & mask;
            d = pat(combo, 3) & mask;

            wr(a);
            chk("R2 set on write", {15'd0, tx_full}, 16'd1);
            @(negedge clk);
            if (!cfg_sel_en) chk("R3 early clear", {15'd0, tx_full}, 16'd0);
            else             chk("R4 still held", {15'd0, tx_full}, 16'd1);

            if (cfg_sel_en) begin
                xfer(pat(combo, 9) & mask, 3, mi);
                chk("R5 abort keeps word", {15'd0, tx_full}, 16'd1);
                chk("R5 abort no rx", {15'd0, rx_full}, 16'd0);
                chk("R5 sdo low deselected", {15'd0, sdo}, 16'd0);
            end

            // first full word: R6 MSB first, R7 edge roles, R8 completion
            xfer(pat(combo, 4) & mask, len, mi);
            chk("R6 R7 sdo word", mi, a);
            chk("R8 rx_rdata", rx_rdata, pat(combo, 4) & mask);
            chk("R8 rx_full", {15'd0, rx_full}, 16'd1);
            chk("R8 irq one cycle after rx_full", 16'(irq_at), 16'(rxf_at + 1));
            chk("R4 cleared after send", {15'd0, tx_full}, 16'd0);

            // nothing loaded, buffer unread
            xfer(pat(combo, 5) & mask, len, mi);
            chk("R11 zeros sent", mi, 16'd0);
            chk("R9 overflow set", {15'd0, rx_ovf}, 16'd1);
            chk("R9 old word kept", rx_rdata, pat(combo, 4) & mask);

            pulse_rd();
            chk("R10 read clears rx_full", {15'd0, rx_full}, 16'd0);
            irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
            chk("R10 irq cleared", {15'd0, irq}, 16'd0);
            chk("R9 overflow sticky", {15'd0, rx_ovf}, 16'd1);
            ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
            chk("R9 ovf_clr", {15'd0, rx_ovf}, 16'd0);

            wr(b);
            if (!cfg_sel_en) begin
                @(negedge clk);
                wr(c);
                chk("R3 second word accepted", {15'd0, tx_full}, 16'd1);
                wr(d);
                xfer(pat(combo, 6) & mask, len, mi);
                chk("R3 first queued word", mi, b);
                chk("R3 next word handed over", {15'd0, tx_full}, 16'd0);
                chk("R8 rx second word", rx_rdata, pat(combo, 6) & mask);
                chk("R8 irq timing again", 16'(irq_at), 16'(rxf_at + 1));
                pulse_rd();
                xfer(pat(combo, 7) & mask, len, mi);
                chk("R2 write while full ignored", mi, c);
            end else begin
                wr(c);
                xfer(pat(combo, 6) & mask, len, mi);
                chk("R2 write while full ignored", mi, b);
                chk("R4 cleared after second word", {15'd0, tx_full}, 16'd0);
                chk("R8 rx second word", rx_rdata, pat(combo, 6) & mask);
                chk("R8 irq timing again", 16'(irq_at), 16'(rxf_at + 1));
            end
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule